// File: doc/BRIEF.md
# Scrambled Line Symbol Decoder with Integrity Flag

This block sits on the receive side of a scrambled serial link. Each 18-bit symbol it accepts carries a 2-bit prefix and a 16-bit scrambled payload. The block runs a local end-around-carry generator that starts from the same seed as the transmitter. It uses that generator to undo the scrambling and the prefix-driven decrement. The recovered words are fed back into the generator, so the local state follows the transmitter's state as long as the channel is clean.

For every data symbol the block rebuilds the prefix that the transmitter should have sent, using its own carry bit and the recovered word. It compares the rebuilt prefix with the received one. The comparisons drive a latched integrity flag. A payload error corrupts the recovered word, so the prefix can disagree even when the prefix bits arrived intact. Once the local state has drifted away from the transmitter, the flag stays low for the rest of the packet.

A prefix of binary 11 can never come out of the half adder. The block treats it as a packet-start marker: it raises a one-cycle strobe and restarts the generator and the flag. An explicit init pulse does the same, and it overrides any symbol presented in the same cycle.

Top module: `scr_line_decoder`

## Requirements
- R1: After synchronous reset, word_valid, start_seen and ok are all 0.
- R2: The generator holds X, Y (16 bits each) and a carry C. Reset, init and a start symbol load X=16'h6DDB, Y=16'hDD6D and C=0. Each accepted data symbol with recovered word M computes t = X+Y+C as a 17-bit sum, then sets X=t[15:0], C=t[16] and Y=(X+M) mod 2^16.
- R3: Symbol bits [17:16] are the prefix and bits [15:0] are the payload. Any prefix other than 2'b11 marks a data symbol. For a data symbol, the recovered word is M = ((payload XOR X) + prefix[17]) mod 2^16, using the X in effect before the update.
- R4: The recovered word appears on word_out with word_valid high in the cycle after the data symbol's sym_valid cycle. In every other cycle word_valid is 0, and word_out holds its last value.
- R5: A symbol with prefix 2'b11 raises start_seen for exactly the following cycle and does not raise word_valid.
- R6: The expected prefix for a data symbol is {C AND M[15], C XOR M[15]}, using the C in effect before the update. The comparison passes when this equals the received prefix.
- R7: ok is 0 after reset, init and a start symbol. The first data word after any of these sets ok to 1 whatever the comparison gives. Each later data word sets ok to (ok AND comparison). ok changes in the same cycle as word_valid.
- R8: Once ok is 0 after the first data word, it stays 0 through any number of clean data words until the next init or start symbol.
- R9: A flip of payload bit 15 on a data word other than the first, with the prefix left intact, drives ok low with that word.
- R10: When init is high, a symbol presented with sym_valid in the same cycle is dropped: no word_valid and no start_seen follow, and the next clean data word decodes against the seed values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Reload generator and restart the integrity flag |
| sym_valid | input | 1 | sym_in holds a symbol this cycle |
| sym_in | input | 18 | Prefix [17:16] and scrambled payload [15:0] |
| word_out | output | 16 | Recovered message word |
| word_valid | output | 1 | word_out was updated this cycle |
| ok | output | 1 | Running integrity flag |
| start_seen | output | 1 | Start marker was received in the previous cycle |

## Verification
Every result is due exactly one cycle after the symbol or pulse that causes it. This applies to word_out, word_valid, ok and start_seen. The bench drives each symbol on a falling edge, lets one rising edge capture it, and samples on the next falling edge. The bench holds a transmit model and a receive model of the generator. It scrambles each word with the transmit model and predicts the word and the flag with the receive model, so corrupted symbols get exact expected values. Idle cycles between symbols check that word_valid and start_seen return to 0.

// File: rtl/peacls_pkg.sv
package peacls_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned SYM_W  = WORD_W + 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [1:0]        prefix_t;
    typedef logic [SYM_W-1:0]  sym_t;

    localparam prefix_t PFX_START = 2'b11;

    typedef struct packed {
        word_t x;
        word_t y;
        logic  c;
    } gen_state_t;

    typedef enum logic [1:0] {
        SYM_IDLE  = 2'd0,
        SYM_DATA  = 2'd1,
        SYM_START = 2'd2
    } sym_kind_t;

    // One end-around-carry step with the recovered word folded into Y.
    function automatic gen_state_t gen_next(gen_state_t s, word_t m);
        gen_state_t     n;
        logic [WORD_W:0] t;
        t   = {1'b0, s.x} + {1'b0, s.y} + {{WORD_W{1'b0}}, s.c};
        n.x = t[WORD_W-1:0];
        n.c = t[WORD_W];
        n.y = s.x + m;
        return n;
    endfunction

    // Half adder: {carry, sum}.
    function automatic prefix_t half_add(logic a, logic b);
        return {a & b, a ^ b};
    endfunction
endpackage

// File: rtl/peac_gen_reg.sv
module peac_gen_reg
    import peacls_pkg::*;
#(
    parameter word_t INIT_X = 16'h6DDB,
    parameter word_t INIT_Y = 16'hDD6D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reload,
    input  logic       advance,
    input  word_t      msg,
    output gen_state_t state
);
    gen_state_t seed;
    assign seed = '{x: INIT_X, y: INIT_Y, c: 1'b0};

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            state <= seed;
        end else if (advance) begin
            state <= gen_next(state, msg);
        end
    end

    // R2: a reload leaves the seed values in place
    p_reload_seed_r2: assert property (@(posedge clk) disable iff (rst)
        reload |=> (state.x == INIT_X && state.y == INIT_Y && !state.c));

    // R2: without reload or advance the state holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!reload && !advance) |=> $stable(state));
endmodule

// File: rtl/sym_recover.sv
module sym_recover
    import peacls_pkg::*;
(
    input  logic      sym_valid,
    input  sym_t      sym_in,
    input  word_t     gen_x,
    input  logic      gen_c,
    output sym_kind_t kind,
    output word_t     msg,
    output logic      match
);
    prefix_t pfx;
    word_t   payload;
    prefix_t rebuilt;

    assign pfx     = sym_in[SYM_W-1 -: 2];
    assign payload = sym_in[WORD_W-1:0];

    always_comb begin
        if (!sym_valid)            kind = SYM_IDLE;
        else if (pfx == PFX_START) kind = SYM_START;
        else                       kind = SYM_DATA;
    end

    assign msg     = (payload ^ gen_x) + {{(WORD_W-1){1'b0}}, pfx[1]};
    assign rebuilt = half_add(gen_c, msg[WORD_W-1]);
    assign match   = (rebuilt == pfx);

    // R3: a start prefix is never classified as data
    always_comb begin
        if (sym_valid && pfx == PFX_START)
            a_start_not_data_r3: assert (kind != SYM_DATA);
    end
endmodule

// File: rtl/ok_tracker.sv
module ok_tracker (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic data_acc,
    input  logic match,
    output logic ok
);
    logic first_pending;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ok            <= 1'b0;
            first_pending <= 1'b1;
        end else if (data_acc) begin
            first_pending <= 1'b0;
            ok            <= first_pending ? 1'b1 : (ok & match);
        end
    end

    // R7: the first data word after a restart raises the flag
    p_first_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (data_acc && first_pending && !restart) |=> ok);

    // R8: a cleared flag stays cleared until a restart
    p_ok_latch_r8: assert property (@(posedge clk) disable iff (rst)
        (!ok && !first_pending && !restart) |=> !ok);

    // R7: restart clears the flag
    p_restart_clear_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !ok);
endmodule

// File: rtl/scr_line_decoder.sv
module scr_line_decoder
    import peacls_pkg::*;
#(
    parameter word_t INIT_X = 16'h6DDB,
    parameter word_t INIT_Y = 16'hDD6D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              sym_valid,
    input  logic [SYM_W-1:0]  sym_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              ok,
    output logic              start_seen
);
    gen_state_t gstate;
    sym_kind_t  kind;
    word_t      msg;
    logic       match;
    logic       data_acc;
    logic       start_acc;

    sym_recover u_recover (
        .sym_valid (sym_valid),
        .sym_in    (sym_in),
        .gen_x     (gstate.x),
        .gen_c     (gstate.c),
        .kind      (kind),
        .msg       (msg),
        .match     (match)
    );

    assign data_acc  = !init && (kind == SYM_DATA);
    assign start_acc = !init && (kind == SYM_START);

    peac_gen_reg #(
        .INIT_X (INIT_X),
        .INIT_Y (INIT_Y)
    ) u_gen (
        .clk     (clk),
        .rst     (rst),
        .reload  (init || start_acc),
        .advance (data_acc),
        .msg     (msg),
        .state   (gstate)
    );

    ok_tracker u_ok (
        .clk      (clk),
        .rst      (rst),
        .restart  (init || start_acc),
        .data_acc (data_acc),
        .match    (match),
        .ok       (ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            start_seen <= 1'b0;
        end else begin
            word_valid <= data_acc;
            start_seen <= start_acc;
            if (data_acc) word_out <= msg;
        end
    end

    // R4: every output word comes from a symbol one cycle earlier
    p_word_follows_sym_r4: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(sym_valid && !init));

    // R5: the start strobe follows a start prefix and never pairs with a word
    p_start_source_r5: assert property (@(posedge clk) disable iff (rst)
        start_seen |-> ($past(sym_valid && sym_in[SYM_W-1 -: 2] == PFX_START) && !word_valid));

    // R10: init suppresses both outputs of a coincident symbol
    p_init_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        init |=> (!word_valid && !start_seen));

    // R4: word_out holds between words
    p_word_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_out));
endmodule

// File: tb/tb_scr_line_decoder.sv
`timescale 1ns/1ps
module tb_scr_line_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0;
    logic        sym_valid = 1'b0;
    logic [17:0] sym_in = '0;
    logic [15:0] word_out;
    logic        word_valid;
    logic        ok;
    logic        start_seen;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scr_line_decoder dut (
        .clk(clk), .rst(rst), .init(init), .sym_valid(sym_valid),
        .sym_in(sym_in), .word_out(word_out), .word_valid(word_valid),
        .ok(ok), .start_seen(start_seen)
    );

    localparam logic [15:0] SX = 16'h6DDB;
    localparam logic [15:0] SY = 16'hDD6D;

    // transmit-side and receive-side reference state
    logic [15:0] tx_x, tx_y, rx_x, rx_y;
    logic        tx_c, rx_c;
    logic        m_ok, m_first;

    task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic seed_tx();
        tx_x = SX; tx_y = SY; tx_c = 1'b0;
    endtask

    task automatic seed_rx();
        rx_x = SX; rx_y = SY; rx_c = 1'b0; m_ok = 1'b0; m_first = 1'b1;
    endtask

    task automatic step(inout logic [15:0] x, inout logic [15:0] y, inout logic c, input logic [15:0] m);
        logic [16:0] t;
        t = {1'b0, x} + {1'b0, y} + {16'd0, c};
        y = x + m;
        x = t[15:0];
        c = t[16];
    endtask

    // Encode m, apply flip, present it, check the decoder.
    task automatic send_word(input logic [15:0] m, input logic [17:0] flip, input string tag);
        logic [1:0]  pfx, rp, ep;
        logic [15:0] pay, rm;
        logic [17:0] s;
        pfx = {tx_c & m[15], tx_c ^ m[15]};
        pay = (m - {15'd0, pfx[1]}) ^ tx_x;
        step(tx_x, tx_y, tx_c, m);
        s = {pfx, pay} ^ flip;
        @(negedge clk);
        sym_in = s; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        rp = s[17:16];
        if (rp == 2'b11) begin
            seed_rx();
            chk(start_seen === 1'b1, {tag, " R5 start"}, start_seen, 1);
            chk(word_valid === 1'b0, {tag, " R5 no word"}, word_valid, 0);
        end else begin
            rm = (s[15:0] ^ rx_x) + {15'd0, rp[1]};
            ep = {rx_c & rm[15], rx_c ^ rm[15]};
            m_ok = m_first ? 1'b1 : (m_ok & (ep == rp));
            m_first = 1'b0;
            step(rx_x, rx_y, rx_c, rm);
            chk(word_valid === 1'b1, {tag, " R4 valid"}, word_valid, 1);
            chk(word_out === rm, {tag, " R3 word"}, word_out, rm);
            chk(ok === m_ok, {tag, " R7 ok"}, ok, m_ok);
            chk(start_seen === 1'b0, {tag, " R5 no start"}, start_seen, 0);
        end
    endtask

    task automatic send_start(input string tag);
        @(negedge clk);
        sym_in = {2'b11, 16'h1234}; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        seed_tx(); seed_rx();
        chk(start_seen === 1'b1, {tag, " R5 strobe"}, start_seen, 1);
        chk(word_valid === 1'b0, {tag, " R5 no word"}, word_valid, 0);
        chk(ok === 1'b0, {tag, " R7 ok cleared"}, ok, 0);
        @(negedge clk);
        chk(start_seen === 1'b0, {tag, " R5 one cycle"}, start_seen, 0);
    endtask

    task automatic pulse_init(input bit with_sym, input string tag);
        @(negedge clk);
        init = 1'b1;
        if (with_sym) begin sym_in = {2'b11, 16'hFFFF}; sym_valid = 1'b1; end
        @(negedge clk);
        init = 1'b0; sym_valid = 1'b0;
        seed_tx(); seed_rx();
        chk(word_valid === 1'b0, {tag, " R10 no word"}, word_valid, 0);
        chk(start_seen === 1'b0, {tag, " R10 no start"}, start_seen, 0);
        chk(ok === 1'b0, {tag, " R7 ok after init"}, ok, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        seed_tx(); seed_rx();
        chk(word_valid === 1'b0, "R1 word_valid", word_valid, 0);
        chk(start_seen === 1'b0, "R1 start_seen", start_seen, 0);
        chk(ok === 1'b0, "R1 ok", ok, 0);
    endtask

    task automatic t_clean_patterns();
        pulse_init(0, "clean");
        send_word(16'h0000, 18'h0, "R2 zeros");
        send_word(16'hFFFF, 18'h0, "R2 ones");
        send_word(16'hAAAA, 18'h0, "R2 alt");
        send_word(16'h8000, 18'h0, "R6 msb");
        for (int i = 0; i < 12; i++)
            send_word(16'(i * 16'h1357 + 16'h0101), 18'h0, "R2 ramp");
        chk(ok === 1'b1, "R6 clean stream ok", ok, 1);
        @(negedge clk);
        chk(word_valid === 1'b0, "R4 idle gap", word_valid, 0);
    endtask

    task automatic t_payload_msb_error();
        send_start("err");
        send_word(16'h4141, 18'h0, "R7 first");
        send_word(16'h4242, 18'h0, "R7 second");
        send_word(16'h4343, 18'h08000, "R9 payload msb");
        chk(ok === 1'b0, "R9 flagged", ok, 0);
        send_word(16'h0000, 18'h0, "R8 pad1");
        send_word(16'h0000, 18'h0, "R8 pad2");
        for (int i = 0; i < 6; i++) send_word(16'(i + 7), 18'h0, "R8 tail");
        chk(ok === 1'b0, "R8 latched", ok, 0);
        send_start("recover");
        send_word(16'h5A5A, 18'h0, "R7 re-arm");
        chk(ok === 1'b1, "R7 re-armed", ok, 1);
    endtask

    task automatic t_misc_errors();
        send_word(16'h1111, 18'h0, "R6 pre");
        send_word(16'h2222, 18'h20000, "R6 prefix hi flip");
        send_word(16'h3333, 18'h0, "R6 post");
        pulse_init(0, "again");
        send_word(16'h0F0F, 18'h0, "R7 first2");
        send_word(16'hF0F0, 18'h00001, "R6 payload lsb");
        for (int i = 0; i < 4; i++) send_word(16'h0000, 18'h0, "R6 pad");
    endtask

    task automatic t_init_collision();
        send_word(16'h7777, 18'h0, "R10 pre");
        pulse_init(1, "collide");
        send_word(16'hBEEF, 18'h0, "R10 after");
        send_word(16'hCAFE, 18'h0, "R10 after2");
        chk(ok === 1'b1, "R10 ok", ok, 1);
    endtask

    initial begin
        t_reset();
        t_clean_patterns();
        t_payload_msb_error();
        t_misc_errors();
        t_init_collision();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule